// File: doc/BRIEF.md
# USB Serial Receive Deserializer

This block takes a recovered USB line bit stream, one bit per clock with a
valid qualifier, and turns it into bytes for a link-side receive port. It
NRZI-decodes every qualified line bit and hunts for the end of the SYNC field.
It then packs payload bits least-significant first, dropping stuff bits on the
way, and recognises the end-of-packet pattern. SYNC and EOP bits are never
delivered as data.

Toward the link, the block raises a bus-direction flag for the whole packet.
It pulses a next-byte strobe each time a byte is ready on the data bus. At the
close of a packet it shows one end cycle that carries a completion kind:
clean, bit-stuff violation, byte misalignment, or elasticity fault. The
elasticity buffer reports its overrun and underrun conditions as two input
flags.

The controller has four states:
- `ST_HUNT`: searches for SYNC.
- `ST_RECV`: receives the payload.
- `ST_ENDP`: a one-cycle end report.
- `ST_DRAIN`: waits for the line to go quiet.

Its transitions are:
- HUNT→RECV on a SYNC match.
- RECV→ENDP on EOP, on a stuff violation, on an elasticity fault, or when the valid qualifier drops.
- ENDP→DRAIN always.
- DRAIN→HUNT once `bit_valid` is low.

Top module: `usb_rx_deser`

## Requirements
- R1: A packet starts only when a decoded one follows a run of at least MIN_SYNC_ZEROS (default 5) decoded zeros. Shorter runs start nothing, and no SYNC bit is ever delivered as data.
- R2: A clean end (kind 0) is seven consecutive decoded ones while exactly six bits, those ones, sit in the partial byte. These EOP bits are never delivered.
- R3: Only cycles with `bit_valid` high carry a bit. A decoded bit is 1 when `line_bit` equals the previous qualified line value (initially 1) and 0 otherwise. Payload bits are packed first-received into bit 0, and every eight bits give one byte.
- R4: The run of decoded ones restarts at zero after SYNC. A zero that arrives after six consecutive ones is a stuff bit and is dropped.
- R5: `link_dir` rises in the cycle after the SYNC match, before any strobe. `link_nxt` is a one-cycle pulse per byte, with the byte on `link_data`, and appears only while `link_dir` is high.
- R6: A seventh consecutive one while the partial byte holds other than six bits ends the packet with kind 1 (stuff error). The partial bits are not delivered.
- R7: Either elasticity flag high during reception ends the packet with kind 3, taking precedence over the bit in that cycle. While hunting, the flags are ignored.
- R8: `bit_valid` low during reception ends the packet. The kind is 2 (alignment error) when the partial byte is non-empty, and 0 when it is empty.
- R9: The end report lasts one cycle, with `link_dir` high, `rx_active` low, `rx_err_kind` showing the kind, and `rx_err` high for a nonzero kind. In the next cycle `link_dir` and `rx_err` are low.
- R10: After an end report, no new packet can start until `bit_valid` has been low for a cycle.
- R11: Out of reset, `link_dir`, `link_nxt`, `rx_active` and `rx_err` are low and `rx_err_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| line_bit | input | 1 | Recovered line level |
| bit_valid | input | 1 | Qualifies `line_bit` in this cycle |
| elas_over | input | 1 | Elasticity buffer overrun flag |
| elas_under | input | 1 | Elasticity buffer underrun flag |
| link_dir | output | 1 | High from SYNC match through end report |
| link_nxt | output | 1 | One-cycle strobe per delivered byte |
| link_data | output | BYTE_W | Delivered byte, valid with `link_nxt` |
| rx_active | output | 1 | High while payload bits are being received |
| rx_err | output | 1 | High in an end cycle with a nonzero kind |
| rx_err_kind | output | 2 | End kind: 0 clean, 1 stuff, 2 align, 3 elasticity |

## Verification
On every cycle, the embedded properties confirm the following:
- A strobe never appears outside the direction window, and never in the first direction cycle.
- An error shows only in the end cycle, and the end cycle is always followed by release.
- A dropped stuff bit never yields a byte.
- A short zero run cannot open a packet.

Only the bench scenarios can show the byte values, the byte count (which proves that SYNC, EOP and stuff bits were stripped), and the classification of each end kind. The same holds for the drain wait after an error and for the inertness of the elasticity flags while hunting.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_RECV  = 2'd1,
        ST_ENDP  = 2'd2,
        ST_DRAIN = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        END_CLEAN = 2'd0,
        END_STUFF = 2'd1,
        END_ALIGN = 2'd2,
        END_ELAS  = 2'd3
    } end_kind_t;
endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic line_bit,
    output logic dec_bit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_q <= 1'b1;
        else if (bit_valid) prev_q <= line_bit;
    end

    assign dec_bit = (line_bit == prev_q);

    // R3: two back-to-back qualified bits decode by level equality
    assert_nrzi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && bit_valid && $past(bit_valid))
            |-> (dec_bit == (line_bit == $past(line_bit))));
endmodule

// File: rtl/usbrx_runs.sv
module usbrx_runs #(
    parameter int MIN_ZEROS = 5,
    parameter int RUN_LIMIT = 6,
    parameter int ZW = $clog2(MIN_ZEROS + 1),
    parameter int OW = $clog2(RUN_LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic dec_bit,
    input  logic restart,
    output logic zeros_ok,
    output logic run_full
);
    logic [ZW-1:0] zeros_q;
    logic [OW-1:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zeros_q <= '0;
            ones_q  <= '0;
        end else if (bit_valid) begin
            if (dec_bit)                         zeros_q <= '0;
            else if (zeros_q != ZW'(MIN_ZEROS))  zeros_q <= zeros_q + ZW'(1);

            if (restart || !dec_bit)             ones_q <= '0;
            else if (ones_q != OW'(RUN_LIMIT+1)) ones_q <= ones_q + OW'(1);
        end
    end

    assign zeros_ok = (zeros_q == ZW'(MIN_ZEROS));
    assign run_full = (ones_q == OW'(RUN_LIMIT));
endmodule

// File: rtl/usbrx_packer.sv
module usbrx_packer #(
    parameter int BYTE_W = 8,
    parameter int CW = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              full,
    output logic [CW-1:0]     fill
);
    logic [BYTE_W-1:0] sh_q;

    assign byte_out = {bit_in, sh_q[BYTE_W-1:1]};
    assign full     = take && (fill == CW'(BYTE_W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            fill <= '0;
        end else if (restart) begin
            fill <= '0;
        end else if (take) begin
            sh_q <= {bit_in, sh_q[BYTE_W-1:1]};
            fill <= full ? '0 : fill + CW'(1);
        end
    end
endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
    import usbrx_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int MIN_SYNC_ZEROS = 5,
    parameter int STUFF_RUN      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_bit,
    input  logic              bit_valid,
    input  logic              elas_over,
    input  logic              elas_under,
    output logic              link_dir,
    output logic              link_nxt,
    output logic [BYTE_W-1:0] link_data,
    output logic              rx_active,
    output logic              rx_err,
    output logic [1:0]        rx_err_kind
);
    localparam int CW = $clog2(BYTE_W);

    rx_state_t   state_q, state_n;
    end_kind_t   end_kind, kind_q;
    logic        dec_bit, zeros_ok, run_full;
    logic        restart, take, full;
    logic        elas;
    logic [CW-1:0]     fill;
    logic [BYTE_W-1:0] byte_w;

    assign elas = elas_over || elas_under;

    usbrx_nrzi u_nrzi (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
        .line_bit(line_bit), .dec_bit(dec_bit)
    );

    usbrx_runs #(.MIN_ZEROS(MIN_SYNC_ZEROS), .RUN_LIMIT(STUFF_RUN)) u_runs (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .dec_bit(dec_bit),
        .restart(restart), .zeros_ok(zeros_ok), .run_full(run_full)
    );

    usbrx_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .restart(restart), .take(take),
        .bit_in(dec_bit), .byte_out(byte_w), .full(full), .fill(fill)
    );

    // next-state and datapath control
    always_comb begin
        state_n  = state_q;
        end_kind = END_CLEAN;
        restart  = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (bit_valid && dec_bit && zeros_ok) begin
                    state_n = ST_RECV;
                    restart = 1'b1;
                end
            end
            ST_RECV: begin
                if (elas) begin
                    state_n  = ST_ENDP;
                    end_kind = END_ELAS;
                end else if (!bit_valid) begin
                    state_n  = ST_ENDP;
                    end_kind = (fill == '0) ? END_CLEAN : END_ALIGN;
                end else if (run_full && dec_bit) begin
                    state_n  = ST_ENDP;
                    end_kind = (fill == CW'(STUFF_RUN)) ? END_CLEAN : END_STUFF;
                end else begin
                    take = !run_full;
                end
            end
            ST_ENDP:  state_n = ST_DRAIN;
            ST_DRAIN: if (!bit_valid) state_n = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_n;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_nxt  <= 1'b0;
            link_data <= '0;
            kind_q    <= END_CLEAN;
            rx_err    <= 1'b0;
        end else begin
            link_nxt <= full;
            if (full) link_data <= byte_w;
            kind_q   <= (state_n == ST_ENDP) ? end_kind : END_CLEAN;
            rx_err   <= (state_n == ST_ENDP) && (end_kind != END_CLEAN);
        end
    end

    assign link_dir    = (state_q == ST_RECV) || (state_q == ST_ENDP);
    assign rx_active   = (state_q == ST_RECV);
    assign rx_err_kind = kind_q;

    assert_nxt_in_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_nxt |-> link_dir);
    assert_dir_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_dir) |-> !link_nxt);
    assert_err_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (link_dir && !rx_active));
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENDP) |=> (!link_dir && !rx_err));
    assert_stuff_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && bit_valid && run_full && !dec_bit && !elas)
            |=> !link_nxt);
    assert_sync_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !zeros_ok) |=> !link_dir);
endmodule

// File: tb/usb_rx_deser_test.sv
`timescale 1ns/1ps
module usb_rx_deser_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_bit = 1'b1, bit_valid = 1'b0, elas_over = 1'b0, elas_under = 1'b0;
    logic link_dir, link_nxt, rx_active, rx_err;
    logic [7:0] link_data;
    logic [1:0] rx_err_kind;

    always #10 clk = ~clk;

    usb_rx_deser uut (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .bit_valid(bit_valid),
        .elas_over(elas_over), .elas_under(elas_under), .link_dir(link_dir),
        .link_nxt(link_nxt), .link_data(link_data), .rx_active(rx_active),
        .rx_err(rx_err), .rx_err_kind(rx_err_kind)
    );

    // fields: [47:44] byte count, [43:40] ending, [39:0] bytes (byte 0 low)
    // ending: 0 EOP, 1 stuff violation, 2 misaligned stop, 3 overrun, 4 underrun
    localparam int NV = 9;
    localparam logic [47:0] VEC [NV] = '{
        {4'd3, 4'd0, 8'h00, 8'h00, 8'h42, 8'h3C, 8'hA5},
        {4'd4, 4'd0, 8'h00, 8'h01, 8'h7E, 8'hFF, 8'hFF},
        {4'd2, 4'd0, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h00},
        {4'd2, 4'd1, 8'h00, 8'h00, 8'h00, 8'h34, 8'h12},
        {4'd1, 4'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h7E},
        {4'd3, 4'd3, 8'h00, 8'h00, 8'hC3, 8'h80, 8'h11},
        {4'd0, 4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {4'd1, 4'd4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h99},
        {4'd5, 4'd0, 8'h3C, 8'h80, 8'h7F, 8'h01, 8'hFE}
    };

    int total = 0, bad = 0;
    logic lvl = 1'b1;
    int run = 0;

    // monitor: written only here
    logic [7:0] got [0:255];
    int nbytes = 0, ends = 0, rises = 0, early = 0, release_bad = 0;
    int last_kind = 0, last_err = 0;
    logic dir_prev = 1'b0, in_end = 1'b0;
    always @(negedge clk) begin
        if (link_nxt) begin
            if (!dir_prev) early++;
            got[nbytes[7:0]] = link_data;
            nbytes++;
        end
        if (in_end && link_dir) release_bad++;
        if (link_dir && !dir_prev) rises++;
        in_end = link_dir && !rx_active;
        if (in_end) begin
            ends++;
            last_kind = int'(rx_err_kind);
            last_err  = int'(rx_err);
        end
        dir_prev = link_dir;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_line(input logic v, input logic lb);
        bit_valid = v;
        line_bit  = lb;
        @(negedge clk);
    endtask

    task automatic send_dec(input logic d);
        if (!d) lvl = ~lvl;
        send_line(1'b1, lvl);
    endtask

    task automatic send_sync(input int nz);
        repeat (nz) send_dec(1'b0);
        send_dec(1'b1);
        run = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_dec(b[i]);
            run = b[i] ? run + 1 : 0;
            if (run == 6) begin
                send_dec(1'b0);
                run = 0;
            end
        end
    endtask

    task automatic send_eop;
        repeat (7) send_dec(1'b1);
    endtask

    task automatic gap(input int n);
        repeat (n) send_line(1'b0, lvl);
    endtask

    task automatic send_elas(input logic o, input logic u);
        lvl = ~lvl;
        elas_over = o;
        elas_under = u;
        send_line(1'b1, lvl);
        elas_over = 1'b0;
        elas_under = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        int base, e0, r0, len, inj;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 dir", int'(link_dir), 0);
        check("R11 nxt", int'(link_nxt), 0);
        check("R11 active", int'(rx_active), 0);
        check("R11 err", int'(rx_err), 0);
        check("R11 kind", int'(rx_err_kind), 0);
        rst_n = 1'b1;
        gap(3);

        for (int v = 0; v < NV; v++) begin
            base = nbytes; e0 = ends;
            len = int'(VEC[v][47:44]);
            inj = int'(VEC[v][43:40]);
            send_sync(8);
            for (int i = 0; i < len; i++) send_byte(VEC[v][i*8 +: 8]);
            case (inj)
                0: send_eop();
                1: begin send_dec(1'b0); repeat (7) send_dec(1'b1); end
                2: repeat (3) send_dec(1'b0);
                3: send_elas(1'b1, 1'b0);
                default: send_elas(1'b0, 1'b1);
            endcase
            gap(6);
            // R1 R2 R4: no sync, eop or stuff bit leaks into the byte count
            check("R1/R2/R4 byte count", nbytes - base, len);
            for (int i = 0; i < len; i++)
                check("R3 byte value", int'(got[(base + i) % 256]), int'(VEC[v][i*8 +: 8]));
            check("R9 one end report", ends - e0, 1);
            // kinds: R2 clean, R6 stuff, R8 align, R7 elasticity
            check("R2/R6/R7/R8 kind", last_kind, (inj == 4) ? 3 : inj);
            check("R9 err flag", last_err, (inj != 0) ? 1 : 0);
        end
        check("R5 strobe before dir", early, 0);
        check("R9 release", release_bad, 0);

        // R1: too-short zero run opens nothing
        r0 = rises;
        send_sync(4);
        gap(4);
        check("R1 short sync", rises - r0, 0);

        // R7: elasticity flags ignored while hunting
        r0 = rises; e0 = ends;
        elas_under = 1'b1; gap(3); elas_under = 1'b0;
        elas_over = 1'b1; gap(2); elas_over = 1'b0;
        check("R7 hunt ignores flags dir", rises - r0, 0);
        check("R7 hunt ignores flags end", ends - e0, 0);

        // R1: exactly the minimum zero run
        base = nbytes;
        send_sync(5); send_byte(8'h33); send_eop(); gap(4);
        check("R1 minimum sync count", nbytes - base, 1);
        check("R1 minimum sync byte", int'(got[base % 256]), 8'h33);

        // R8: valid drop on a byte boundary is a clean end
        base = nbytes;
        send_sync(8); send_byte(8'h5A); gap(4);
        check("R8 boundary stop kind", last_kind, 0);
        check("R8 boundary stop bytes", nbytes - base, 1);

        // R10: after an error, no resync until the line goes quiet
        r0 = rises; e0 = ends;
        send_sync(8); send_byte(8'h24);
        send_dec(1'b0); repeat (7) send_dec(1'b1);
        send_sync(8); send_byte(8'h18); send_eop();
        gap(4);
        check("R10 single packet", rises - r0, 1);
        check("R10 single end", ends - e0, 1);
        check("R6 stuff kind", last_kind, 1);

        // R10: after quiet, a new packet is accepted
        base = nbytes;
        send_sync(8); send_byte(8'h66); send_eop(); gap(4);
        check("R10 resync after idle", nbytes - base, 1);
        check("R5 strobe before dir final", early, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule